// File: doc/BRIEF.md
# Coherent Modulo Timer Counter

This block is a timer counter whose width is twice the width of its byte bus (16 bits by default). It advances one step on each cycle in which the prescaled count-enable input is high. A programmable modulo value sets the limit. Two counting modes are selectable. The up mode wraps to zero after the limit. The center mode climbs to the limit, then descends back to zero, then climbs again.

Each pass through the limit raises a sticky overflow flag, and an enable bit gates that flag onto an interrupt line. The modulo value and the counter are reached through separate high and low byte registers, and both directions are kept coherent:

- A modulo update takes effect only once both of its bytes are in, and the flag stays blocked while the update is half done.
- Reading the counter high byte captures the low byte, so a 16-bit read does not tear.

A debug-freeze input stops the counter and holds the capture buffer as it is.

Top module: `coh_mod_timer`

## Requirements
- R1: After reset, the following all read 0 and the interrupt output is low: the control register, both counter bytes and both modulo bytes. The register addresses are 0 control, 1 counter high, 2 counter low, 3 modulo high and 4 modulo low. The control bits are bit 0 center mode, bit 1 interrupt enable and bit 7 overflow flag.
- R2: In up mode with a nonzero modulo M, the counter steps 0,1,...,M on each cycle with count-enable high. The next step returns it to 0 and sets the flag. Cycles with count-enable low leave the counter unchanged.
- R3: With a modulo of 0, the counter runs over the full range. Its step from 0xFFFF goes to 0x0000 and sets the flag.
- R4: In center mode the counter climbs to M. The next step goes to M-1 and sets the flag. On reaching 0 while descending, the next step goes to 1.
- R5: After a write to one modulo byte, the flag does not set on overflow until the other modulo byte has been written.
- R6: A modulo byte reads back the value last written to it. The limit used for counting changes only after both bytes have been written.
- R7: A read of the counter high byte captures the low byte. The next read of the low byte returns the captured value and releases the capture. A later low-byte read returns the live value.
- R8: A write of any value to either counter byte sets the counter to 0 and releases the capture buffer.
- R9: While freeze is high, the counter holds its value, and counter byte reads neither capture nor release the buffer.
- R10: Writing control with bit 7 set clears the flag, and writing it with bit 7 clear leaves the flag as it is. The interrupt output is high exactly when both the flag and the interrupt-enable bit are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Prescaled count enable, one step per high cycle |
| freeze | input | 1 | Debug freeze of counter and capture buffer |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, acts at the clock edge |
| bus_rd | input | 1 | Read strobe; side effects act at the clock edge |
| bus_wdata | input | BW | Write data |
| bus_rdata | output | BW | Read data, combinational from address |
| irq | output | 1 | Overflow interrupt request |

## Verification
The bench builds the block with its default BW of 8, so the counter is 16 bits wide. A full free-running lap of 65536 steps therefore fits within the run, and the 0xFFFF-to-0 wrap of R3 is observed directly. Small modulo values of 2 to 5 bring the up-mode wrap and both center-mode turns within a few steps. The modulo value 0x0102 exercises a limit whose high byte is in use.

// File: rtl/modtmr_pkg.sv
package modtmr_pkg;
  typedef enum logic [2:0] {
    A_CTRL = 3'd0,
    A_CNTH = 3'd1,
    A_CNTL = 3'd2,
    A_MODH = 3'd3,
    A_MODL = 3'd4
  } reg_addr_e;

  localparam int CB_CENTER = 0;
  localparam int CB_IE     = 1;
endpackage

// File: rtl/modtmr_core.sv
module modtmr_core #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          clear,
  input  logic          center,
  input  logic [CW-1:0] mod_act,
  output logic [CW-1:0] cnt_q,
  output logic          dir_up_q,
  output logic          ovf_evt
);
  function automatic logic [CW-1:0] f_limit(input logic [CW-1:0] m);
    return (m == '0) ? '1 : m;
  endfunction

  logic [CW-1:0] lim, nxt;
  logic          nxt_up, wrap;

  always_comb begin
    lim    = f_limit(mod_act);
    nxt    = cnt_q + 1'b1;
    nxt_up = 1'b1;
    wrap   = 1'b0;
    if (center) begin
      if (dir_up_q) begin
        if (cnt_q == lim) begin
          nxt    = cnt_q - 1'b1;
          nxt_up = 1'b0;
          wrap   = 1'b1;
        end
      end else if (cnt_q == '0) begin
        nxt = cnt_q + 1'b1;
      end else begin
        nxt    = cnt_q - 1'b1;
        nxt_up = 1'b0;
      end
    end else if (cnt_q == lim) begin
      nxt  = '0;
      wrap = 1'b1;
    end
  end

  assign ovf_evt = tick & wrap & ~clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      dir_up_q <= 1'b1;
    end else if (clear) begin
      cnt_q    <= '0;
      dir_up_q <= 1'b1;
    end else if (tick) begin
      cnt_q    <= nxt;
      dir_up_q <= nxt_up;
    end
  end
endmodule

// File: rtl/modtmr_regs.sv
module modtmr_regs #(
  parameter int BW = 8,
  localparam int CW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctrl,
  input  logic          wr_modh,
  input  logic          wr_modl,
  input  logic [BW-1:0] wdata,
  input  logic          ovf_evt,
  output logic          center,
  output logic          ie,
  output logic          flag,
  output logic [BW-1:0] modh_q,
  output logic [BW-1:0] modl_q,
  output logic [CW-1:0] mod_act,
  output logic          mod_pend
);
  import modtmr_pkg::*;

  logic pend_h, pend_l, commit;

  assign mod_pend = pend_h | pend_l;
  assign commit   = (pend_h | wr_modh) & (pend_l | wr_modl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      center  <= 1'b0;
      ie      <= 1'b0;
      flag    <= 1'b0;
      modh_q  <= '0;
      modl_q  <= '0;
      mod_act <= '0;
      pend_h  <= 1'b0;
      pend_l  <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        center <= wdata[CB_CENTER];
        ie     <= wdata[CB_IE];
      end
      if (ovf_evt && !mod_pend) flag <= 1'b1;
      else if (wr_ctrl && wdata[BW-1]) flag <= 1'b0;
      if (wr_modh) modh_q <= wdata;
      if (wr_modl) modl_q <= wdata;
      if (commit) begin
        mod_act <= {wr_modh ? wdata : modh_q, wr_modl ? wdata : modl_q};
        pend_h  <= 1'b0;
        pend_l  <= 1'b0;
      end else begin
        if (wr_modh) pend_h <= 1'b1;
        if (wr_modl) pend_l <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/modtmr_rdbuf.sv
module modtmr_rdbuf #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_hi,
  input  logic          rd_lo,
  input  logic          freeze,
  input  logic          clear,
  input  logic [BW-1:0] live_lo,
  output logic [BW-1:0] lo_out,
  output logic          buf_vld
);
  logic [BW-1:0] buf_q;

  assign lo_out = buf_vld ? buf_q : live_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q   <= '0;
      buf_vld <= 1'b0;
    end else if (clear) begin
      buf_vld <= 1'b0;
    end else if (!freeze) begin
      if (rd_hi) begin
        buf_q   <= live_lo;
        buf_vld <= 1'b1;
      end else if (rd_lo) begin
        buf_vld <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/coh_mod_timer.sv
module coh_mod_timer #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic          freeze,
  input  logic [2:0]    bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [BW-1:0] bus_wdata,
  output logic [BW-1:0] bus_rdata,
  output logic          irq
);
  import modtmr_pkg::*;
  localparam int CW = 2 * BW;

  logic          wr_ctrl, wr_modh, wr_modl, cnt_clr, rd_hi, rd_lo, tick;
  logic          center, ie, flag, mod_pend, dir_up, ovf_evt, buf_vld;
  logic [BW-1:0] modh_q, modl_q, lo_out;
  logic [CW-1:0] mod_act, cnt_q;

  assign wr_ctrl = bus_wr & (bus_addr == A_CTRL);
  assign wr_modh = bus_wr & (bus_addr == A_MODH);
  assign wr_modl = bus_wr & (bus_addr == A_MODL);
  assign cnt_clr = bus_wr & ((bus_addr == A_CNTH) | (bus_addr == A_CNTL));
  assign rd_hi   = bus_rd & (bus_addr == A_CNTH);
  assign rd_lo   = bus_rd & (bus_addr == A_CNTL);
  assign tick    = cnt_en & ~freeze;

  modtmr_regs #(.BW(BW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_modh(wr_modh),
    .wr_modl(wr_modl), .wdata(bus_wdata), .ovf_evt(ovf_evt),
    .center(center), .ie(ie), .flag(flag), .modh_q(modh_q),
    .modl_q(modl_q), .mod_act(mod_act), .mod_pend(mod_pend)
  );

  modtmr_core #(.CW(CW)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clear(cnt_clr),
    .center(center), .mod_act(mod_act), .cnt_q(cnt_q),
    .dir_up_q(dir_up), .ovf_evt(ovf_evt)
  );

  modtmr_rdbuf #(.BW(BW)) u_rdbuf (
    .clk(clk), .rst_n(rst_n), .rd_hi(rd_hi), .rd_lo(rd_lo),
    .freeze(freeze), .clear(cnt_clr), .live_lo(cnt_q[BW-1:0]),
    .lo_out(lo_out), .buf_vld(buf_vld)
  );

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {flag, {(BW-3){1'b0}}, ie, center};
      A_CNTH:  bus_rdata = cnt_q[CW-1:BW];
      A_CNTL:  bus_rdata = lo_out;
      A_MODH:  bus_rdata = modh_q;
      A_MODL:  bus_rdata = modl_q;
      default: bus_rdata = '0;
    endcase
  end

  assign irq = flag & ie;
endmodule

// File: rtl/modtmr_chk.sv
module modtmr_chk #(
  parameter int BW = 8,
  localparam int CW = 2 * BW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          freeze,
  input logic          cnt_clr,
  input logic [CW-1:0] cnt_q,
  input logic          dir_up,
  input logic          center,
  input logic [CW-1:0] mod_act,
  input logic          mod_pend,
  input logic          flag,
  input logic          ie,
  input logic          irq,
  input logic          wr_ctrl,
  input logic [BW-1:0] wdata,
  input logic          ovf_evt,
  input logic          buf_vld,
  input logic          rd_lo
);
  // R2: up-mode step at the limit lands on zero
  a_r2_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !center && !cnt_clr && mod_act != '0 && cnt_q == mod_act) |=> (cnt_q == '0));

  // R4: center mode turns downward at the limit
  a_r4_turn_down: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && center && dir_up && !cnt_clr && mod_act != '0 && cnt_q == mod_act) |=> !dir_up);

  // R5: no flag rise while a modulo update is half written
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_pend && !flag) |=> !flag);

  // R8: counter write zeroes the counter and the capture
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (cnt_q == '0 && !buf_vld));

  // R9: freeze holds the counter
  a_r9_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !cnt_clr) |=> $stable(cnt_q));

  // R7: low read releases the capture when not frozen
  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lo && !freeze) |=> !buf_vld);

  // R10: clear request without a concurrent overflow empties the flag
  a_r10_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && wdata[BW-1] && !ovf_evt) |=> !flag);

  // R10: interrupt never raised while disabled
  a_r10_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !ie |-> !irq);
endmodule

bind coh_mod_timer modtmr_chk #(.BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .freeze(freeze),
  .cnt_clr(cnt_clr), .cnt_q(cnt_q), .dir_up(dir_up), .center(center),
  .mod_act(mod_act), .mod_pend(mod_pend), .flag(flag), .ie(ie),
  .irq(irq), .wr_ctrl(wr_ctrl), .wdata(bus_wdata), .ovf_evt(ovf_evt),
  .buf_vld(buf_vld), .rd_lo(rd_lo)
);

// File: tb/sim_coh_mod_timer.sv
module sim_coh_mod_timer;
  logic       clk = 1'b0, rst_n = 1'b0, cnt_en = 1'b0, freeze = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00, bus_rdata;
  logic       irq;
  int         checks = 0, errors = 0;
  logic [7:0] rv, rv2;

  always #2.5 clk = ~clk;

  coh_mod_timer #(.BW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .freeze(freeze),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  typedef struct packed {
    logic        center;
    logic [15:0] modv;
    logic [19:0] ticks;
    logic [15:0] exp_cnt;
    logic        exp_flag;
  } vec_t;

  localparam vec_t TBL [12] = '{
    '{1'b0, 16'd5,     20'd3,     16'd3,     1'b0},  // R2
    '{1'b0, 16'd5,     20'd5,     16'd5,     1'b0},  // R2
    '{1'b0, 16'd5,     20'd6,     16'd0,     1'b1},  // R2
    '{1'b0, 16'd5,     20'd8,     16'd2,     1'b1},  // R2
    '{1'b0, 16'h0102,  20'h102,   16'h0102,  1'b0},  // R2
    '{1'b0, 16'h0102,  20'h103,   16'h0000,  1'b1},  // R2
    '{1'b1, 16'd4,     20'd4,     16'd4,     1'b0},  // R4
    '{1'b1, 16'd4,     20'd5,     16'd3,     1'b1},  // R4
    '{1'b1, 16'd4,     20'd8,     16'd0,     1'b1},  // R4
    '{1'b1, 16'd4,     20'd9,     16'd1,     1'b1},  // R4
    '{1'b1, 16'd4,     20'd12,    16'd4,     1'b1},  // R4
    '{1'b1, 16'd4,     20'd13,    16'd3,     1'b1}   // R4
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    cnt_en = 1'b1;
    repeat (n) @(negedge clk);
    cnt_en = 1'b0;
  endtask

  task automatic rd_cnt(output logic [15:0] v);
    logic [7:0] h, l;
    rd(3'd1, h);
    rd(3'd2, l);
    v = {h, l};
  endtask

  task automatic set_mod(input logic [15:0] m);
    wr(3'd3, m[15:8]);
    wr(3'd4, m[7:0]);
  endtask

  initial begin
    #750000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] cv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(3'd0, rv); chk("R1 ctrl", {8'h0, rv}, 16'h0000);
    rd_cnt(cv);   chk("R1 counter", cv, 16'h0000);
    rd(3'd3, rv); chk("R1 modh", {8'h0, rv}, 16'h0000);
    rd(3'd4, rv); chk("R1 modl", {8'h0, rv}, 16'h0000);
    chk("R1 irq", {15'h0, irq}, 16'h0000);

    // R2 / R4 vector walk; idle cycle with cnt_en low shows no count
    foreach (TBL[i]) begin
      wr(3'd0, {1'b1, 5'd0, 1'b1, TBL[i].center});
      set_mod(TBL[i].modv);
      wr(3'd2, 8'h00);
      ticks(int'(TBL[i].ticks));
      repeat (2) @(negedge clk);
      rd_cnt(cv);
      chk(TBL[i].center ? "R4 count" : "R2 count", cv, TBL[i].exp_cnt);
      rd(3'd0, rv);
      chk(TBL[i].center ? "R4 flag" : "R2 flag", {15'h0, rv[7]}, {15'h0, TBL[i].exp_flag});
      chk("R10 irq follows flag", {15'h0, irq}, {15'h0, TBL[i].exp_flag});
    end

    // R5 / R6 half-written modulo
    wr(3'd0, 8'h82);
    set_mod(16'h0003);
    wr(3'd2, 8'h00);
    wr(3'd3, 8'h01);
    ticks(4);
    rd_cnt(cv);   chk("R6 old limit still used", cv, 16'h0000);
    rd(3'd0, rv); chk("R5 flag blocked", {15'h0, rv[7]}, 16'h0000);
    rd(3'd3, rv); chk("R6 modh readback", {8'h0, rv}, 16'h0001);
    wr(3'd4, 8'h00);
    wr(3'd2, 8'h00);
    ticks(16'h0101);
    rd_cnt(cv);   chk("R6 new limit wrap", cv, 16'h0000);
    rd(3'd0, rv); chk("R5 flag after both bytes", {15'h0, rv[7]}, 16'h0001);

    // R7 coherent read
    wr(3'd0, 8'h80);
    set_mod(16'h0000);
    wr(3'd2, 8'h00);
    ticks(16'h01FE);
    rd(3'd1, rv); chk("R7 high byte", {8'h0, rv}, 16'h0001);
    ticks(3);
    rd(3'd2, rv); chk("R7 buffered low", {8'h0, rv}, 16'h00FE);
    rd(3'd2, rv); chk("R7 live low after release", {8'h0, rv}, 16'h0001);

    // R9 freeze
    rd(3'd1, rv); chk("R9 setup high", {8'h0, rv}, 16'h0002);
    ticks(2);
    @(negedge clk); freeze = 1'b1;
    ticks(4);
    rd(3'd2, rv); chk("R9 frozen low buffered", {8'h0, rv}, 16'h0001);
    rd(3'd2, rv); chk("R9 buffer kept in freeze", {8'h0, rv}, 16'h0001);
    rd(3'd1, rv2); chk("R9 high in freeze", {8'h0, rv2}, 16'h0002);
    @(negedge clk); freeze = 1'b0;
    rd(3'd2, rv); chk("R9 release after freeze", {8'h0, rv}, 16'h0001);
    rd(3'd2, rv); chk("R9 counter held", {8'h0, rv}, 16'h0003);

    // R8 counter write
    wr(3'd1, 8'h55);
    rd_cnt(cv);   chk("R8 cleared", cv, 16'h0000);
    rd(3'd1, rv);
    ticks(5);
    wr(3'd2, 8'hAA);
    ticks(2);
    rd(3'd2, rv); chk("R8 buffer released", {8'h0, rv}, 16'h0002);

    // R10 write-one-to-clear and enable gate
    wr(3'd0, 8'h80);
    set_mod(16'h0002);
    wr(3'd2, 8'h00);
    ticks(3);
    rd(3'd0, rv); chk("R10 flag set", {15'h0, rv[7]}, 16'h0001);
    chk("R10 irq gated off", {15'h0, irq}, 16'h0000);
    wr(3'd0, 8'h02);
    rd(3'd0, rv); chk("R10 zero write keeps flag", {15'h0, rv[7]}, 16'h0001);
    chk("R10 irq enabled", {15'h0, irq}, 16'h0001);
    wr(3'd0, 8'h82);
    rd(3'd0, rv); chk("R10 flag cleared", {15'h0, rv[7]}, 16'h0000);
    chk("R10 irq dropped", {15'h0, irq}, 16'h0000);

    // R3 free-running lap
    wr(3'd0, 8'h80);
    set_mod(16'h0000);
    wr(3'd2, 8'h00);
    ticks(65535);
    rd_cnt(cv);   chk("R3 top of range", cv, 16'hFFFF);
    rd(3'd0, rv); chk("R3 no flag yet", {15'h0, rv[7]}, 16'h0000);
    ticks(1);
    rd_cnt(cv);   chk("R3 wrapped", cv, 16'h0000);
    rd(3'd0, rv); chk("R3 flag on wrap", {15'h0, rv[7]}, 16'h0001);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule